// File: doc/BRIEF.md
# Software-Increment Event Counter Bank

This block holds a bank of event counters that software can advance by writing one mask register. Every counter has a programmable event selector. When the mask register is written, each counter that gets a 1 in its mask bit advances by one in that cycle, provided its selector holds the software-increment code 0x00 and the counter is enabled. Counters with any other selector ignore their mask bit. The mask register stores nothing, so a later cycle cannot repeat an increment.

One optional hardware pulse input per counter stands in for the counter's selected hardware event. Each counter can be preset through the configuration port, which is needed to bring a counter near its wrap point. Each counter also has a sticky overflow flag that is set when the counter wraps and is cleared by writing 1 to it. One counter and its selector can be read back at a time through an index.

The reset input is asynchronous and active-low. It is released synchronously inside the block through a two-stage synchronizer.

Top module: `swinc_counter_bank`

## Requirements
- R1: After reset, every counter reads 0, every event selector reads 0x00, every overflow flag is 0, and reading the mask register returns 0.
- R2: A mask write with bit m set (m from 0 to NUM_CTRS-1) increments counter m by one in the cycle after the strobe, when counter m is enabled and its selector equals 0x00.
- R3: A mask bit set for a counter whose selector is not 0x00 leaves that counter unchanged.
- R4: A mask bit of 0 leaves its counter unchanged. Bit NUM_CTRS (bit 31 with the default parameters) is reserved, and writing it changes no counter.
- R5: One mask write increments every qualifying counter in the written subset together, each by exactly one.
- R6: A counter whose enable input is 0 does not advance, neither from a mask bit nor from a hardware pulse.
- R7: A hardware pulse advances an enabled counter by one, whatever its selector. A software increment and a hardware pulse on the same counter in the same cycle advance it by two.
- R8: An increment that carries past 0xFFFFFFFF wraps the counter and sets that counter's overflow flag. The flag stays set until a clear write with a 1 in its bit. If a wrap and a clear fall in the same cycle, the flag is left set.
- R9: The mask register keeps nothing: reads always return 0, and a cycle without the write strobe increments no counter through the mask path.
- R10: A preset write to counter k loads the written value, and it takes precedence over any increment of counter k in that same cycle. The readback outputs show the counter and selector picked by the read index, combinationally, and return 0 for an index past the last counter.
- R11: A selector write updates the selector of the indexed counter from the next cycle. An increment in the same cycle as the selector write uses the old selector value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| swinc_we | input | 1 | Decoded write strobe for the increment mask register |
| swinc_wdata | input | 32 | Increment mask; bit m drives counter m, the top bit is reserved |
| swinc_rd_data | output | 32 | Read value of the increment mask register, always 0 |
| cfg_idx | input | 5 | Counter index for selector and preset writes |
| cfg_evt_we | input | 1 | Selector write strobe |
| cfg_evt | input | 8 | New event selector value |
| cfg_cnt_we | input | 1 | Counter preset strobe |
| cfg_cnt | input | 32 | Counter preset value |
| ctr_en | input | 31 | Per-counter enable |
| hw_evt | input | 31 | Per-counter hardware event pulse |
| ovf_clr_we | input | 1 | Overflow clear strobe |
| ovf_clr_mask | input | 31 | Overflow flags to clear (write 1 to clear) |
| rd_idx | input | 5 | Readback counter index |
| rd_cnt | output | 32 | Value of the indexed counter |
| rd_evt | output | 8 | Selector of the indexed counter |
| ovf_flags | output | 31 | Sticky overflow flags |

## Verification
The assertions assume that the enable and pulse inputs are stable, known levels at every clock edge, and that the preset and selector writes touch only one counter per cycle, through a valid index. They also assume that a counter can move only through one of its three paths: a qualifying mask bit, a hardware pulse, or a preset. The stimulus drives every input only at the falling edge. It draws indices from the implemented counter range, with an occasional out-of-range read index. It keeps hardware pulses sparse and presets rare, so that most cycles exercise the mask path on its own. Presets load values just below the wrap point, so that overflow and the clear race come up often.

// File: rtl/swinc_pkg.sv
package swinc_pkg;

  // Event selector code that routes a counter to the software-increment path
  parameter int unsigned EVT_W_DEF   = 8;
  parameter logic [7:0]  SWINC_EVENT = 8'h00;

  // Per-counter increment request produced by the decoder
  typedef struct packed {
    logic sw;   // qualified software increment
    logic hw;   // hardware pulse
  } hit_t;

endpackage

// File: rtl/swinc_rst_sync.sv
module swinc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/swinc_decode.sv
module swinc_decode
  import swinc_pkg::*;
#(
  parameter int unsigned NUM_CTRS = 31,
  parameter int unsigned EVT_W    = 8,
  parameter logic [EVT_W-1:0] SW_CODE = '0,
  localparam int unsigned MASK_W  = NUM_CTRS + 1
) (
  input  logic                           wr_en,
  input  logic [MASK_W-1:0]              wr_mask,
  input  logic [NUM_CTRS-1:0][EVT_W-1:0] evt_sel,
  input  logic [NUM_CTRS-1:0]            hw_pulse,
  output hit_t [NUM_CTRS-1:0]            hits
);

  // Only the implemented counter bits pass; the top bit is reserved.
  localparam logic [MASK_W-1:0] IMPL_MASK = {1'b0, {NUM_CTRS{1'b1}}};

  logic [MASK_W-1:0] mask_eff;

  always_comb begin
    mask_eff = wr_mask & IMPL_MASK & {MASK_W{wr_en}};
  end

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_hit
    always_comb begin
      hits[g].sw = mask_eff[g] && (evt_sel[g] == SW_CODE);
      hits[g].hw = hw_pulse[g];
    end
  end

endmodule

// File: rtl/swinc_ctr_slice.sv
module swinc_ctr_slice
  import swinc_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hit_t             hit,
  input  logic             en,
  input  logic             evt_we,
  input  logic [EVT_W-1:0] evt_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [EVT_W-1:0] evt,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic             ovf_q, ovf_d;
  logic             cnt_ce, evt_ce, ovf_ce;
  logic [1:0]       step;
  logic [CNT_W:0]   sum;
  logic             wrap;

  // Next-state logic
  always_comb begin
    step   = {1'b0, en & hit.sw} + {1'b0, en & hit.hw};
    sum    = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, step};
    if (cnt_we) begin
      cnt_d = cnt_wdata;
      wrap  = 1'b0;
    end else begin
      cnt_d = sum[CNT_W-1:0];
      wrap  = sum[CNT_W];
    end
    cnt_ce = cnt_we | (|step);

    evt_d  = evt_wdata;
    evt_ce = evt_we;

    // A wrap in the same cycle wins over a clear
    ovf_d  = (ovf_q & ~ovf_clr) | wrap;
    ovf_ce = ovf_clr | wrap;
  end

  // State registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else if (evt_ce) begin
      evt_q <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (ovf_ce) begin
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign evt = evt_q;
  assign ovf = ovf_q;

endmodule

// File: rtl/swinc_counter_bank.sv
module swinc_counter_bank
  import swinc_pkg::*;
#(
  parameter int unsigned NUM_CTRS = 31,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned EVT_W    = EVT_W_DEF,
  localparam int unsigned MASK_W  = NUM_CTRS + 1,
  localparam int unsigned IDX_W   = $clog2(NUM_CTRS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                swinc_we,
  input  logic [MASK_W-1:0]   swinc_wdata,
  output logic [MASK_W-1:0]   swinc_rd_data,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_evt_we,
  input  logic [EVT_W-1:0]    cfg_evt,
  input  logic                cfg_cnt_we,
  input  logic [CNT_W-1:0]    cfg_cnt,
  input  logic [NUM_CTRS-1:0] ctr_en,
  input  logic [NUM_CTRS-1:0] hw_evt,
  input  logic                ovf_clr_we,
  input  logic [NUM_CTRS-1:0] ovf_clr_mask,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CNT_W-1:0]    rd_cnt,
  output logic [EVT_W-1:0]    rd_evt,
  output logic [NUM_CTRS-1:0] ovf_flags
);

  localparam logic [EVT_W-1:0] SW_CODE = EVT_W'(SWINC_EVENT);

  logic                           rst_sync_n;
  hit_t [NUM_CTRS-1:0]            hits;
  logic [NUM_CTRS-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CTRS-1:0][EVT_W-1:0] evt_all;
  logic [NUM_CTRS-1:0]            preset_sel;
  logic [NUM_CTRS-1:0]            evt_sel_we;
  logic [NUM_CTRS-1:0]            clr_vec;

  swinc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swinc_decode #(
    .NUM_CTRS (NUM_CTRS),
    .EVT_W    (EVT_W),
    .SW_CODE  (SW_CODE)
  ) u_decode (
    .wr_en    (swinc_we),
    .wr_mask  (swinc_wdata),
    .evt_sel  (evt_all),
    .hw_pulse (hw_evt),
    .hits     (hits)
  );

  always_comb begin
    clr_vec = ovf_clr_mask & {NUM_CTRS{ovf_clr_we}};
  end

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    always_comb begin
      preset_sel[g] = cfg_cnt_we && (cfg_idx == IDX_W'(g));
      evt_sel_we[g] = cfg_evt_we && (cfg_idx == IDX_W'(g));
    end

    swinc_ctr_slice #(
      .CNT_W (CNT_W),
      .EVT_W (EVT_W)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .hit       (hits[g]),
      .en        (ctr_en[g]),
      .evt_we    (evt_sel_we[g]),
      .evt_wdata (cfg_evt),
      .cnt_we    (preset_sel[g]),
      .cnt_wdata (cfg_cnt),
      .ovf_clr   (clr_vec[g]),
      .cnt       (cnt_all[g]),
      .evt       (evt_all[g]),
      .ovf       (ovf_flags[g])
    );
  end

  // Readback multiplexer; out-of-range index returns zero
  always_comb begin
    rd_cnt = '0;
    rd_evt = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_cnt = cnt_all[i];
        rd_evt = evt_all[i];
      end
    end
  end

  // The increment mask register holds no state
  assign swinc_rd_data = '0;

endmodule

// File: rtl/swinc_counter_bank_chk.sv
module swinc_counter_bank_chk #(
  parameter int unsigned NUM_CTRS = 31,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned EVT_W    = 8,
  localparam int unsigned MASK_W  = NUM_CTRS + 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           swinc_we,
  input logic [MASK_W-1:0]              swinc_wdata,
  input logic [NUM_CTRS-1:0]            ctr_en,
  input logic [NUM_CTRS-1:0]            hw_evt,
  input logic [NUM_CTRS-1:0]            preset_sel,
  input logic [NUM_CTRS-1:0][EVT_W-1:0] evt_all,
  input logic [NUM_CTRS-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CTRS-1:0]            ovf_flags,
  input logic                           ovf_clr_we,
  input logic [NUM_CTRS-1:0]            ovf_clr_mask
);

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_chk
    // R4
    zero_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(swinc_we && swinc_wdata[g]) && !hw_evt[g] && !preset_sel[g])
      |=> $stable(cnt_all[g]));

    // R3
    sel_mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swinc_we && swinc_wdata[g] && (evt_all[g] != '0) && !hw_evt[g] && !preset_sel[g])
      |=> $stable(cnt_all[g]));

    // R6
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_en[g] && !preset_sel[g]) |=> $stable(cnt_all[g]));

    // R8
    ovf_rise_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flags[g]) |-> (cnt_all[g] < $past(cnt_all[g])));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flags[g] && !(ovf_clr_we && ovf_clr_mask[g])) |=> ovf_flags[g]);

    // R2
    sw_inc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swinc_we && swinc_wdata[g] && ctr_en[g] && (evt_all[g] == '0)
       && !hw_evt[g] && !preset_sel[g])
      |=> (cnt_all[g] == $past(cnt_all[g]) + CNT_W'(1)));
  end

endmodule

bind swinc_counter_bank swinc_counter_bank_chk #(
  .NUM_CTRS (NUM_CTRS),
  .CNT_W    (CNT_W),
  .EVT_W    (EVT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .swinc_we     (swinc_we),
  .swinc_wdata  (swinc_wdata),
  .ctr_en       (ctr_en),
  .hw_evt       (hw_evt),
  .preset_sel   (preset_sel),
  .evt_all      (evt_all),
  .cnt_all      (cnt_all),
  .ovf_flags    (ovf_flags),
  .ovf_clr_we   (ovf_clr_we),
  .ovf_clr_mask (ovf_clr_mask)
);

// File: tb/tb_swinc_counter_bank.sv
`timescale 1ns/10ps
module tb_swinc_counter_bank;

  localparam real CLK_PERIOD = 10.0;
  localparam int  N      = 31;
  localparam int  CW     = 32;
  localparam int  EW     = 8;
  localparam int  MW     = N + 1;
  localparam int  IW     = 5;
  localparam int  WDOG   = 200000;

  logic          clk;
  logic          rst_n;
  logic          swinc_we;
  logic [MW-1:0] swinc_wdata;
  logic [MW-1:0] swinc_rd_data;
  logic [IW-1:0] cfg_idx;
  logic          cfg_evt_we;
  logic [EW-1:0] cfg_evt;
  logic          cfg_cnt_we;
  logic [CW-1:0] cfg_cnt;
  logic [N-1:0]  ctr_en;
  logic [N-1:0]  hw_evt;
  logic          ovf_clr_we;
  logic [N-1:0]  ovf_clr_mask;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] rd_cnt;
  logic [EW-1:0] rd_evt;
  logic [N-1:0]  ovf_flags;

  swinc_counter_bank dut (
    .clk (clk), .rst_n (rst_n),
    .swinc_we (swinc_we), .swinc_wdata (swinc_wdata), .swinc_rd_data (swinc_rd_data),
    .cfg_idx (cfg_idx), .cfg_evt_we (cfg_evt_we), .cfg_evt (cfg_evt),
    .cfg_cnt_we (cfg_cnt_we), .cfg_cnt (cfg_cnt),
    .ctr_en (ctr_en), .hw_evt (hw_evt),
    .ovf_clr_we (ovf_clr_we), .ovf_clr_mask (ovf_clr_mask),
    .rd_idx (rd_idx), .rd_cnt (rd_cnt), .rd_evt (rd_evt), .ovf_flags (ovf_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2.0) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [CW-1:0] exp_cnt [N];
  logic [EW-1:0] exp_evt [N];
  logic [N-1:0]  exp_ovf;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference step from the requirements, evaluated on the inputs of this cycle
  task automatic model_step();
    logic [CW:0]   sum;
    logic [1:0]    step;
    logic [N-1:0]  wrap;
    wrap = '0;
    for (int i = 0; i < N; i++) begin
      step = 2'd0;
      if (ctr_en[i]) begin
        if (swinc_we && swinc_wdata[i] && exp_evt[i] == 8'h00) step = step + 2'd1;
        if (hw_evt[i]) step = step + 2'd1;
      end
      if (cfg_cnt_we && cfg_idx == IW'(i)) begin
        exp_cnt[i] = cfg_cnt;
      end else begin
        sum = {1'b0, exp_cnt[i]} + {31'd0, step};
        exp_cnt[i] = sum[CW-1:0];
        wrap[i] = sum[CW];
      end
      if (cfg_evt_we && cfg_idx == IW'(i)) exp_evt[i] = cfg_evt;
    end
    exp_ovf = (exp_ovf & ~(ovf_clr_we ? ovf_clr_mask : '0)) | wrap;
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i);
      #0.1;
      chk(tag, $sformatf("cnt[%0d]", i), 64'(rd_cnt), 64'(exp_cnt[i]));
      chk(tag, $sformatf("evt[%0d]", i), 64'(rd_evt), 64'(exp_evt[i]));
    end
    chk(tag, "ovf_flags", 64'(ovf_flags), 64'(exp_ovf));
  endtask

  task automatic clear_strobes();
    swinc_we = 0; swinc_wdata = '0; cfg_evt_we = 0; cfg_cnt_we = 0;
    hw_evt = '0; ovf_clr_we = 0; ovf_clr_mask = '0;
  endtask

  // One cycle: model, clock edge, compare, return at falling edge with strobes idle
  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    #1;
    compare_all(tag);
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic single_cnt(string tag, int idx, logic [CW-1:0] exp);
    rd_idx = IW'(idx);
    #0.1;
    chk(tag, $sformatf("directed cnt[%0d]", idx), 64'(rd_cnt), 64'(exp));
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; rd_idx = '0; cfg_idx = '0; cfg_evt = '0; cfg_cnt = '0; ctr_en = '0;
    clear_strobes();
    for (int i = 0; i < N; i++) begin exp_cnt[i] = '0; exp_evt[i] = '0; end
    exp_ovf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    compare_all("R1");
    chk("R1", "swinc_rd_data", 64'(swinc_rd_data), 64'd0);

    ctr_en = '1;
    // R2 and R5: bits 0 and 2 together
    swinc_we = 1; swinc_wdata = 32'h0000_0005;
    tick("R5");
    single_cnt("R2", 0, 32'd1);
    single_cnt("R2", 2, 32'd1);

    // R4: reserved bit 31 only
    swinc_we = 1; swinc_wdata = 32'h8000_0000;
    tick("R4");
    // R4: zero mask
    swinc_we = 1; swinc_wdata = 32'h0;
    tick("R4");

    // R11: selector of counter 1 to 0x11; same-cycle increment uses old selector
    cfg_idx = 5'd1; cfg_evt_we = 1; cfg_evt = 8'h11; swinc_we = 1; swinc_wdata = 32'h2;
    tick("R11");
    single_cnt("R11", 1, 32'd1);
    // R3: now mismatched selector ignores its bit
    swinc_we = 1; swinc_wdata = 32'h2;
    tick("R3");
    single_cnt("R3", 1, 32'd1);

    // R6: counter 3 disabled
    ctr_en[3] = 0; swinc_we = 1; swinc_wdata = 32'h8; hw_evt[3] = 1;
    tick("R6");
    single_cnt("R6", 3, 32'd0);
    ctr_en[3] = 1;

    // R7: sw and hw together on counter 0
    swinc_we = 1; swinc_wdata = 32'h1; hw_evt[0] = 1;
    tick("R7");
    single_cnt("R7", 0, 32'd3);

    // R8: wrap on counter 4
    cfg_idx = 5'd4; cfg_cnt_we = 1; cfg_cnt = 32'hFFFF_FFFF;
    tick("R10");
    swinc_we = 1; swinc_wdata = 32'h10;
    tick("R8");
    single_cnt("R8", 4, 32'd0);
    chk("R8", "ovf[4] set", 64'(ovf_flags[4]), 64'd1);
    tick("R8");
    chk("R8", "ovf[4] sticky", 64'(ovf_flags[4]), 64'd1);
    // R8: wrap and clear race on counter 4
    cfg_idx = 5'd4; cfg_cnt_we = 1; cfg_cnt = 32'hFFFF_FFFE;
    tick("R10");
    hw_evt[4] = 1; swinc_we = 1; swinc_wdata = 32'h10; ovf_clr_we = 1; ovf_clr_mask = 31'h10;
    tick("R8");
    chk("R8", "ovf[4] wrap beats clear", 64'(ovf_flags[4]), 64'd1);
    single_cnt("R8", 4, 32'd0);
    ovf_clr_we = 1; ovf_clr_mask = 31'h10;
    tick("R8");
    chk("R8", "ovf[4] cleared", 64'(ovf_flags[4]), 64'd0);

    // R10: preset beats increment in the same cycle
    cfg_idx = 5'd5; cfg_cnt_we = 1; cfg_cnt = 32'h1234_5678; swinc_we = 1; swinc_wdata = 32'h20;
    tick("R10");
    single_cnt("R10", 5, 32'h1234_5678);
    rd_idx = 5'd31;
    #0.1;
    chk("R10", "out-of-range read", 64'(rd_cnt), 64'd0);

    // R9: no strobe, data present, nothing moves; read returns zero
    swinc_we = 0; swinc_wdata = 32'h7FFF_FFFF;
    tick("R9");
    chk("R9", "swinc_rd_data", 64'(swinc_rd_data), 64'd0);

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      swinc_we    = ($urandom % 3) != 0;
      swinc_wdata = $urandom;
      hw_evt      = N'($urandom & $urandom & $urandom);
      if ($urandom % 32 == 0) ctr_en = N'($urandom | $urandom);
      cfg_idx     = IW'($urandom % N);
      cfg_evt_we  = ($urandom % 8) == 0;
      cfg_evt     = ($urandom % 2 == 0) ? 8'h00 : EW'($urandom % 4);
      cfg_cnt_we  = ($urandom % 6) == 0;
      cfg_cnt     = 32'hFFFF_FFF0 | CW'($urandom % 16);
      ovf_clr_we  = ($urandom % 4) == 0;
      ovf_clr_mask = N'($urandom);
      tick("R2/R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule